// File: doc/BRIEF.md
# Data Tenure Termination Tracker

This block sits on the master side of a split-transaction processor bus. It follows one data tenure from the cycle the master takes the data bus until the tenure finishes. A tenure finishes in one of three ways: it completes its beats, an error acknowledge cuts it short, or an address retry inside the retry window aborts it. While the tenure runs, the block holds the data-bus-busy pin asserted. Each beat stays in a wait state until the slave acknowledges it. For every accepted beat the block emits a capture strobe and the number of that beat. When the tenure ends it emits one termination pulse: done, error or abort.

The block also watches the slave for protocol faults. It flags an acknowledge that comes too early in the retry window or that lingers past the last beat. It flags an error acknowledge given while the bus is not busy, and one held for more than one cycle. An error termination raises a one-cycle machine-check request. The exception itself is handled elsewhere.

Top module: `dtenure_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `dbb_n_o` is 1 and `cap_o`, `done_o`, `err_o`, `mcheck_o`, `abort_o` and `viol_o` are all 0.
- R2: A beat is accepted only on a clock edge where the acknowledge is sampled asserted. Otherwise the beat waits for any number of cycles. Each accepted beat makes `cap_o` high for the one cycle after that edge, and in that cycle `beat_o` holds the beat's number.
- R3: A tenure started with `burst_i`=1 has BEATS beats (default 4), numbered 0 to BEATS-1 in order. A tenure started with `burst_i`=0 has one beat, numbered 0. The beat number advances only on an accepted acknowledge.
- R4: After the final beat is accepted, `done_o` is high for one cycle and `dbb_n_o` returns to 1 in that same cycle.
- R5: An error acknowledge sampled during an active tenure ends the tenure. An acknowledge in the same cycle is ignored and gives no strobe. In the next cycle `dbb_n_o` is 1 and `err_o` and `mcheck_o` pulse for one cycle. Strobes of earlier beats are unaffected.
- R6: When `retry_en_i` is 1, the first RETRY_WIN cycles of a tenure (default 2) form the retry window. An address retry in the window aborts the tenure: there is no strobe, and in the next cycle `abort_o` pulses and `dbb_n_o` is 1. An address retry outside the window, or with `retry_en_i`=0, has no effect.
- R7: An acknowledge inside the retry window, with `retry_en_i`=1, is not accepted. It sets `viol_o[0]` for the next cycle.
- R8: An acknowledge sampled in the cycle right after the final beat sets `viol_o[1]` for the next cycle.
- R9: An error acknowledge sampled while no tenure is active sets `viol_o[2]` for the next cycle.
- R10: An error acknowledge sampled on two consecutive edges sets `viol_o[3]` for the cycle after the second edge.
- R11: `start_i` is ignored while a tenure is active.
- R12: `ta_n_i`, `tea_n_i`, `artry_n_i` and `dbb_n_o` are active low: 0 means asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a tenure; only acted on when idle |
| burst_i | input | 1 | 1 for a multi-beat burst, 0 for a single beat |
| retry_en_i | input | 1 | Enables the address-retry window |
| ta_n_i | input | 1 | Transfer acknowledge, active low |
| tea_n_i | input | 1 | Transfer error acknowledge, active low |
| artry_n_i | input | 1 | Address retry, active low |
| dbb_n_o | output | 1 | Data bus busy, active low |
| cap_o | output | 1 | Beat capture strobe |
| beat_o | output | IDX_W | Number of the captured beat |
| done_o | output | 1 | Normal completion pulse |
| err_o | output | 1 | Error termination pulse |
| mcheck_o | output | 1 | Machine-check request pulse |
| abort_o | output | 1 | Retry abort pulse |
| viol_o | output | 4 | Protocol violation flags: bit0 early acknowledge, bit1 lingering acknowledge, bit2 stray error acknowledge, bit3 long error acknowledge |

## Verification
The embedded assertions check these on every cycle:
- a strobe is always preceded by a sampled acknowledge;
- a single transfer only ever strobes beat 0;
- the done pulse coincides with bus release;
- an error acknowledge ends the tenure without a strobe;
- the retry window is open only during a tenure;
- a doubled error acknowledge always raises its flag.

Some behaviour only the bench scenarios can show:
- unbounded wait states between burst beats;
- ignored starts during a tenure;
- an error acknowledge landing on the final beat;
- an address retry inside versus outside the window;
- exact flag timing against a behavioural model.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} tenure_st_e;

    localparam int VIOL_W       = 4;
    localparam int V_EARLY_ACK  = 0;
    localparam int V_LATE_ACK   = 1;
    localparam int V_STRAY_ERR  = 2;
    localparam int V_LONG_ERR   = 3;
endpackage

// File: rtl/dtt_window.sv
module dtt_window #(
    parameter int RETRY_WIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic act_i,
    output logic in_win_o
);
    localparam int CW = $clog2(RETRY_WIN + 1);
    localparam logic [CW-1:0] WLIM = CW'(RETRY_WIN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (open_i)
            cnt_d = '0;
        else if (act_i && cnt_q < WLIM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= WLIM;
        else     cnt_q <= cnt_d;
    end

    assign in_win_o = act_i && (cnt_q < WLIM);

    a_r6_win_only_busy: assert property (@(posedge clk) disable iff (rst)
        in_win_o |-> act_i);
    a_r6_win_restarts: assert property (@(posedge clk) disable iff (rst)
        open_i |=> (cnt_q == '0));
endmodule

// File: rtl/dtt_beat_ctrl.sv
module dtt_beat_ctrl
    import dtt_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             burst_i,
    input  logic             ta_i,
    input  logic             tea_i,
    input  logic             artry_i,
    input  logic             retry_en_i,
    input  logic             in_win_i,
    output logic             act_o,
    output logic             cap_o,
    output logic [$clog2(BEATS)-1:0] beat_o,
    output logic             done_o,
    output logic             err_o,
    output logic             abort_o
);
    localparam int IDX_W = $clog2(BEATS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    typedef struct packed {
        tenure_st_e       st;
        logic [IDX_W-1:0] idx;
        logic             burst;
        logic             cap;
        logic [IDX_W-1:0] beat;
        logic             done;
        logic             err;
        logic             abort;
    } ctrl_s;

    ctrl_s d, q;
    logic  gate;
    logic  final_beat;

    assign gate       = retry_en_i && in_win_i;
    assign final_beat = !q.burst || (q.idx == LAST_IDX);

    always_comb begin
        d       = q;
        d.cap   = 1'b0;
        d.done  = 1'b0;
        d.err   = 1'b0;
        d.abort = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_BUSY;
                    d.idx   = '0;
                    d.burst = burst_i;
                end
            end
            ST_BUSY: begin
                if (gate && artry_i) begin
                    d.st    = ST_IDLE;
                    d.abort = 1'b1;
                end else if (tea_i) begin
                    d.st  = ST_IDLE;
                    d.err = 1'b1;
                end else if (ta_i && !gate) begin
                    d.cap  = 1'b1;
                    d.beat = q.idx;
                    if (final_beat) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: ST_IDLE, idx: '0, burst: 1'b0, cap: 1'b0,
                   beat: '0, done: 1'b0, err: 1'b0, abort: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign act_o   = (q.st == ST_BUSY);
    assign cap_o   = q.cap;
    assign beat_o  = q.beat;
    assign done_o  = q.done;
    assign err_o   = q.err;
    assign abort_o = q.abort;

    a_r2_cap_needs_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_o) |-> $past(ta_i));
    a_r3_single_beat0: assert property (@(posedge clk) disable iff (rst)
        (cap_o && !q.burst) |-> (beat_o == '0));
    a_r4_done_releases: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !act_o);
    a_r5_err_ends: assert property (@(posedge clk) disable iff (rst)
        (act_o && tea_i && !(gate && artry_i)) |=> (err_o && !act_o && !cap_o));
    a_r5_single_term: assert property (@(posedge clk) disable iff (rst)
        $countones({done_o, err_o, abort_o}) <= 1);
endmodule

// File: rtl/dtt_monitor.sv
module dtt_monitor
    import dtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ta_i,
    input  logic              tea_i,
    input  logic              act_i,
    input  logic              gate_i,
    input  logic              done_i,
    output logic [VIOL_W-1:0] viol_o
);
    logic [VIOL_W-1:0] viol_d, viol_q;
    logic              tea_prev_d, tea_prev_q;

    always_comb begin
        viol_d               = '0;
        viol_d[V_EARLY_ACK]  = act_i && gate_i && ta_i;
        viol_d[V_LATE_ACK]   = done_i && ta_i;
        viol_d[V_STRAY_ERR]  = tea_i && !act_i;
        viol_d[V_LONG_ERR]   = tea_i && tea_prev_q;
        tea_prev_d           = tea_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q     <= '0;
            tea_prev_q <= 1'b0;
        end else begin
            viol_q     <= viol_d;
            tea_prev_q <= tea_prev_d;
        end
    end

    assign viol_o = viol_q;

    a_r10_long_err: assert property (@(posedge clk) disable iff (rst)
        (tea_prev_q && tea_i) |=> viol_o[V_LONG_ERR]);
    a_r9_stray_err: assert property (@(posedge clk) disable iff (rst)
        (tea_i && !act_i) |=> viol_o[V_STRAY_ERR]);
endmodule

// File: rtl/dtenure_tracker.sv
module dtenure_tracker
    import dtt_pkg::*;
#(
    parameter int BEATS     = 4,
    parameter int RETRY_WIN = 2,
    localparam int IDX_W    = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              burst_i,
    input  logic              retry_en_i,
    input  logic              ta_n_i,
    input  logic              tea_n_i,
    input  logic              artry_n_i,
    output logic              dbb_n_o,
    output logic              cap_o,
    output logic [IDX_W-1:0]  beat_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mcheck_o,
    output logic              abort_o,
    output logic [VIOL_W-1:0] viol_o
);
    logic ta, tea, artry;
    logic act, in_win, done;

    // pins are active low; the core works on active-high copies
    assign ta    = ~ta_n_i;
    assign tea   = ~tea_n_i;
    assign artry = ~artry_n_i;

    dtt_window #(.RETRY_WIN(RETRY_WIN)) u_win (
        .clk      (clk),
        .rst      (rst),
        .open_i   (start_i && !act),
        .act_i    (act),
        .in_win_o (in_win)
    );

    dtt_beat_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .burst_i    (burst_i),
        .ta_i       (ta),
        .tea_i      (tea),
        .artry_i    (artry),
        .retry_en_i (retry_en_i),
        .in_win_i   (in_win),
        .act_o      (act),
        .cap_o      (cap_o),
        .beat_o     (beat_o),
        .done_o     (done),
        .err_o      (err_o),
        .abort_o    (abort_o)
    );

    dtt_monitor u_mon (
        .clk    (clk),
        .rst    (rst),
        .ta_i   (ta),
        .tea_i  (tea),
        .act_i  (act),
        .gate_i (retry_en_i && in_win),
        .done_i (done),
        .viol_o (viol_o)
    );

    assign done_o   = done;
    assign mcheck_o = err_o;
    assign dbb_n_o  = ~act;

    a_r12_busy_pin: assert property (@(posedge clk) disable iff (rst)
        (start_i && dbb_n_o) |=> !dbb_n_o);
endmodule

// File: tb/sim_dtenure_tracker.sv
module sim_dtenure_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, burst = 0, ren = 0;
    logic ta_n = 1, tea_n = 1, artry_n = 1;
    logic dbb_n, cap, done, err, mc, abrt;
    logic [1:0] beat;
    logic [3:0] viol;

    int checks = 0, errors = 0, cycles = 0;
    int caps_seen = 0;

    // behavioural model state
    bit m_act = 0, m_burst = 0, m_doneprev = 0, m_teaprev = 0;
    int m_idx = 0, m_cnt = 2;
    bit e_cap = 0, e_done = 0, e_err = 0, e_abort = 0;
    int e_beat = 0;
    bit [3:0] e_viol = 0;

    localparam int W = 2;
    localparam int NB = 4;

    always #5 clk = ~clk;

    dtenure_tracker u0 (
        .clk(clk), .rst(rst), .start_i(start), .burst_i(burst),
        .retry_en_i(ren), .ta_n_i(ta_n), .tea_n_i(tea_n), .artry_n_i(artry_n),
        .dbb_n_o(dbb_n), .cap_o(cap), .beat_o(beat), .done_o(done),
        .err_o(err), .mcheck_o(mc), .abort_o(abrt), .viol_o(viol)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // one clock: drive inputs, advance the model, compare after the edge
    task automatic cyc(input bit s, input bit b, input bit a, input bit e, input bit r);
        bit win;
        start = s; burst = b; ta_n = !a; tea_n = !e; artry_n = !r;
        win = m_act && ren && (m_cnt < W);
        e_cap = 0; e_done = 0; e_err = 0; e_abort = 0;
        e_viol = '0;
        e_viol[0] = win && a;
        e_viol[1] = m_doneprev && a;
        e_viol[2] = e && !m_act;
        e_viol[3] = e && m_teaprev;
        m_teaprev = e;
        if (!m_act) begin
            if (s) begin m_act = 1; m_idx = 0; m_burst = b; m_cnt = 0; end
        end else begin
            if (m_cnt < W) m_cnt++;
            if (win && r) begin m_act = 0; e_abort = 1; end
            else if (e) begin m_act = 0; e_err = 1; end
            else if (a && !win) begin
                e_cap = 1; e_beat = m_idx;
                if (!m_burst || m_idx == NB - 1) begin m_act = 0; e_done = 1; end
                else m_idx++;
            end
        end
        m_doneprev = e_done;
        @(negedge clk);
        if (cap) caps_seen++;
        chk(dbb_n == !m_act, "R4/R5/R6/R12 dbb_n", dbb_n, !m_act);
        chk(cap == e_cap, "R2 cap", cap, e_cap);
        if (e_cap) chk(beat == e_beat[1:0], "R3 beat", beat, e_beat);
        chk(done == e_done, "R4 done", done, e_done);
        chk(err == e_err && mc == e_err, "R5 err/mcheck", {err, mc}, {e_err, e_err});
        chk(abrt == e_abort, "R6 abort", abrt, e_abort);
        chk(viol[0] == e_viol[0], "R7 early ack flag", viol[0], e_viol[0]);
        chk(viol[1] == e_viol[1], "R8 late ack flag", viol[1], e_viol[1]);
        chk(viol[2] == e_viol[2], "R9 stray err flag", viol[2], e_viol[2]);
        chk(viol[3] == e_viol[3], "R10 long err flag", viol[3], e_viol[3]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dbb_n == 1 && !cap && !done && !err && !mc && !abrt && viol == 0,
            "R1 reset", {dbb_n, cap, done, err, abrt}, 5'b10000);
        rst = 0;
        cyc(0, 0, 0, 0, 0);

        // R2/R3: single beat after two wait states
        cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0);
        idle(2);

        // R2/R3/R8: burst with wait states between beats, ack lingers after last
        cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
        idle(2);

        // R11: burst back-to-back with starts pulsed while active
        caps_seen = 0;
        cyc(1, 1, 0, 0, 0);
        cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0); cyc(1, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
        idle(1);
        chk(caps_seen == 4, "R11 start ignored while active", caps_seen, 4);

        // R5/R9/R10: error with ack in same cycle mid-burst, then held a second cycle
        cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 1, 0); cyc(0, 0, 0, 1, 0);
        idle(2);

        // R9: stray error while idle
        cyc(0, 0, 0, 1, 0); idle(2);

        // R5: error on the final beat of a single transfer wins over ack
        cyc(1, 0, 0, 0, 0); cyc(0, 0, 1, 1, 0); idle(2);

        // R6/R7: retry enabled; early ack ignored, ack accepted after window
        ren = 1;
        cyc(1, 0, 0, 0, 0); cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
        idle(2);
        // R6: retry inside window aborts without strobe
        cyc(1, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 1, 0, 1);
        idle(2);
        // R6: retry after window is ignored
        cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1); cyc(0, 0, 1, 0, 0);
        idle(2);
        // R6: retry disabled, retry in first cycle ignored
        ren = 0;
        cyc(1, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1); cyc(0, 0, 1, 0, 0);
        idle(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule